// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order in which column addresses are visited during one DRAM read or write burst. A single-cycle start strobe supplies the starting column, a 3-bit burst-length code and a 1-bit ordering select. Starting on the next cycle, the block emits one column address per cycle with a valid flag. It raises a final-beat flag on the closing beat.

The low two or three column bits are reordered. The scheme is either a modulo count that wraps inside the aligned burst block, or the starting bits XORed with the beat number. All other column bits stay at their starting value for the whole burst. A start that arrives on the final beat chains a new burst with no gap. The length and ordering settings are captured at the start and do not change until the burst ends.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and whenever no burst is running, `beatValid` and `beatLast` are 0 and `beatCol` is all zeros.
- R2: `lenCode` 3'b011 selects an 8-beat burst; every other code selects a 4-beat burst. `beatValid` stays high for exactly that many consecutive cycles. `beatLast` is high only on the final one, and the output goes idle on the next cycle unless a new burst is chained.
- R3: With `typeSel` = 0 (sequential), beat k carries low bits (s + k) mod L, where s is the start column's low bits and L is the burst length. For example, L = 4 and s = 2 gives the order 2,3,0,1.
- R4: With `typeSel` = 1 (interleaved), beat k carries low bits s XOR k. For example, L = 8 and s = 5 gives the order 5,4,7,6,1,0,3,2.
- R5: For L = 4, only column bits 1:0 are reordered, and bit 2 and above equal the start column. For L = 8, bits 2:0 are reordered, and bits 3 and above equal the start column.
- R6: A start strobe on the final beat of a burst makes the first beat of the new burst appear on the very next cycle.
- R7: A start strobe on any beat of a running burst other than the final one is ignored, and the running burst continues unchanged.
- R8: `lenCode` and `typeSel` are sampled only when a start is accepted. Changing them during a burst does not affect that burst.
- R9: The first beat appears one cycle after the accepted start strobe and carries the start column unchanged, in both orderings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Request to begin a burst |
| startCol | input | COL_W | Starting column address |
| lenCode | input | 3 | Burst-length code (3'b011 = 8 beats, others = 4) |
| typeSel | input | 1 | Ordering: 0 sequential, 1 interleaved |
| beatValid | output | 1 | A beat address is present |
| beatCol | output | COL_W | Column address of the current beat |
| beatLast | output | 1 | Current beat is the final one of the burst |

## Verification
The bench builds the block with COL_W = 6, so the start column has only 64 values. This makes it possible to sweep every start column against both lengths and both orderings, comparing every beat with an address computed arithmetically. The bench also drives the remaining length codes and chains bursts across length and ordering changes. It injects mid-burst start strobes and scrambles the mode inputs while bursts run, which exercises the sampling and ignore rules on every burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int ORDER_W = 3;
  localparam logic [2:0] LEN8_CODE = 3'b011;
  localparam logic [ORDER_W-1:0] LAST4 = 3'd3;
  localparam logic [ORDER_W-1:0] LAST8 = 3'd7;

  typedef struct packed {
    logic               load;
    logic               active;
    logic               len8;
    logic               ilv;
    logic [ORDER_W-1:0] idx;
  } seqStrobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startStb,
  input  logic [2:0] lenCode,
  input  logic       typeSel,
  output seqStrobe_t strobes,
  output logic       beatValid,
  output logic       beatLast
);

  logic               busyQ;
  logic [ORDER_W-1:0] idxQ;
  logic               len8Q;
  logic               ilvQ;
  logic               lastBeat;
  logic               accept;

  assign lastBeat = busyQ && (idxQ == (len8Q ? LAST8 : LAST4));
  assign accept   = startStb && (!busyQ || lastBeat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      len8Q <= 1'b0;
      ilvQ  <= 1'b0;
    end else if (accept) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
      len8Q <= (lenCode == LEN8_CODE);
      ilvQ  <= typeSel;
    end else if (lastBeat) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (busyQ) begin
      idxQ  <= idxQ + 3'd1;
    end
  end

  always_comb begin
    strobes.load   = accept;
    strobes.active = busyQ;
    strobes.len8   = len8Q;
    strobes.ilv    = ilvQ;
    strobes.idx    = idxQ;
  end

  assign beatValid = busyQ;
  assign beatLast  = lastBeat;

  // R2: beat index advances by one on each non-final beat
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ && !lastBeat && !startStb |=> busyQ && idxQ == $past(idxQ) + 3'd1);

  // R2: a burst that ends with no chained start goes idle
  p_end_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat && !startStb |=> !busyQ);

  // R6: start on the final beat restarts at beat zero next cycle
  p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat && startStb |=> busyQ && idxQ == '0);

  // R7: start on a non-final beat does not restart the burst
  p_ignore_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ && !lastBeat |=> idxQ != '0);

  // R8: captured mode holds while a burst runs
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ && !accept |=> $stable(len8Q) && $stable(ilvQ));

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] startCol,
  input  seqStrobe_t       strobes,
  output logic [COL_W-1:0] beatCol
);

  localparam int UPPER_W = COL_W - ORDER_W;

  logic [COL_W-1:0]   baseQ;
  logic [ORDER_W-1:0] mask;
  logic [ORDER_W-1:0] lowStart;
  logic [ORDER_W-1:0] seqLow;
  logic [ORDER_W-1:0] ilvLow;
  logic [ORDER_W-1:0] pick;
  logic [ORDER_W-1:0] mergedLow;

  always_ff @(posedge clk) begin
    if (!rst_n)            baseQ <= '0;
    else if (strobes.load) baseQ <= startCol;
  end

  always_comb begin
    mask      = strobes.len8 ? 3'b111 : 3'b011;
    lowStart  = baseQ[ORDER_W-1:0] & mask;
    seqLow    = lowStart + strobes.idx;
    ilvLow    = lowStart ^ strobes.idx;
    pick      = strobes.ilv ? ilvLow : seqLow;
    mergedLow = (baseQ[ORDER_W-1:0] & ~mask) | (pick & mask);
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign beatCol = strobes.active ? {baseQ[COL_W-1:ORDER_W], mergedLow} : '0;
    end else begin : g_narrow
      assign beatCol = strobes.active ? mergedLow[COL_W-1:0] : '0;
    end
  endgenerate

  // R9: first beat carries the start column as presented
  p_first_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> beatCol == $past(startCol));

  // R5: bits above the reorder field hold through a running burst
  p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.active && !strobes.load |=> !strobes.active || strobes.load ||
      $stable(beatCol[COL_W-1:ORDER_W]));

  // R1: idle output is zero
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.active |-> beatCol == '0);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             typeSel,
  output logic             beatValid,
  output logic [COL_W-1:0] beatCol,
  output logic             beatLast
);

  seqStrobe_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startStb  (startStb),
    .lenCode   (lenCode),
    .typeSel   (typeSel),
    .strobes   (strobes),
    .beatValid (beatValid),
    .beatLast  (beatLast)
  );

  burst_seq_datapath #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .startCol (startCol),
    .strobes  (strobes),
    .beatCol  (beatCol)
  );

  // R2: final-beat flag only accompanies a valid beat
  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beatLast |-> beatValid);

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  localparam int COL_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = 3'b010;
  logic             typeSel = 1'b0;
  logic             beatValid;
  logic [COL_W-1:0] beatCol;
  logic             beatLast;

  int nChecks = 0;
  int nFails  = 0;
  int scr     = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .startCol(startCol),
    .lenCode(lenCode), .typeSel(typeSel),
    .beatValid(beatValid), .beatCol(beatCol), .beatLast(beatLast)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expCol(input int col, input int len, input bit ilv, input int k);
    int m  = len - 1;
    int lo = col & m;
    int r  = ilv ? (lo ^ k) : ((lo + k) % len);
    return (col & ~m & ((1 << COL_W) - 1)) | r;
  endfunction

  task automatic scramble();
    scr++;
    startStb = 1'b0;
    startCol = COL_W'(scr * 13 + 7);
    lenCode  = 3'(scr * 5 + 1);
    typeSel  = scr[0];
  endtask

  task automatic present(input int col, input int code, input bit ilv);
    startStb = 1'b1;
    startCol = COL_W'(col);
    lenCode  = 3'(code);
    typeSel  = ilv;
  endtask

  // start already presented; checks each beat, optionally chains or injects a mid-burst start
  task automatic runBurst(input int col, input int code, input bit ilv,
                          input bit chain, input int nCol, input int nCode, input bit nIlv,
                          input bit noise);
    int len = (code == 3) ? 8 : 4;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(ilv ? "R4 valid" : "R3 valid", int'(beatValid), 1);
      chk(ilv ? "R4 order R5 upper" : "R3 order R5 upper", int'(beatCol), expCol(col, len, ilv, k));
      chk("R2 last flag", int'(beatLast), (k == len - 1) ? 1 : 0);
      if (k == len - 1 && chain)      present(nCol, nCode, nIlv);
      else if (noise && k == 1)       present(col ^ 6'h2a, (code == 3) ? 2 : 3, ~ilv);
      else                            scramble();
    end
  endtask

  task automatic checkIdle(input string req);
    @(negedge clk);
    chk(req, int'(beatValid), 0);
    chk(req, int'(beatLast), 0);
    chk(req, int'(beatCol), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", int'(beatValid), 0);
    chk("R1 reset last", int'(beatLast), 0);
    chk("R1 reset col", int'(beatCol), 0);
    present(5, 3, 1'b1);           // start held during reset must not launch
    @(negedge clk);
    chk("R1 start in reset", int'(beatValid), 0);
    scramble();
    rst_n = 1'b1;
    checkIdle("R1 idle after reset");

    // R3/R4/R5/R9: exhaustive sweep over start column, length, ordering
    for (int c = 0; c < 64; c++)
      for (int code = 2; code <= 3; code++)
        for (int t = 0; t < 2; t++) begin
          @(negedge clk);
          present(c, code, t[0]);
          runBurst(c, code, t[0], 1'b0, 0, 0, 1'b0, 1'b0);
          checkIdle("R2 idle after burst");
        end

    // R2: other length codes give 4 beats
    for (int code = 0; code < 8; code++) begin
      if (code == 3) continue;
      @(negedge clk);
      present(45, code, code[0]);
      runBurst(45, 2, code[0], 1'b0, 0, 0, 1'b0, 1'b0);
      checkIdle("R2 short code idle");
    end

    // R3 example 2,3,0,1 chained (R6) into R4 example 5,4,7,6,1,0,3,2
    @(negedge clk);
    present(6'h12, 2, 1'b0);
    runBurst(6'h12, 2, 1'b0, 1'b1, 6'h25, 3, 1'b1, 1'b0);
    runBurst(6'h25, 3, 1'b1, 1'b1, 6'h3e, 2, 1'b1, 1'b0);   // R6 chain again
    runBurst(6'h3e, 2, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    checkIdle("R6 chain end idle");

    // R7/R8: mid-burst starts ignored, running mode unchanged
    for (int t = 0; t < 2; t++)
      for (int code = 2; code <= 3; code++) begin
        @(negedge clk);
        present(6'h1d, code, t[0]);
        runBurst(6'h1d, code, t[0], 1'b0, 0, 0, 1'b0, 1'b1);
        checkIdle("R7 ignored start idle");
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule